// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Burst Addressing

This block is a synthesizable model of a single-clock static RAM built so that a shared data bus never needs an idle cycle between reads and writes. Every command (address, read/write select, per-lane write enables, advance) is captured on the rising clock edge. Write data follows its command one edge later in flow-through mode and two edges later in pipelined mode, which is the same point at which read data would occupy the bus. Because of this, reads and writes can be interleaved freely, one per cycle.

A static mode input chooses between the two read timings. In flow-through mode, the read register drives the bus right after the command edge. In pipelined mode, one further register stage delays it by one more edge. A second static input chooses whether four-beat bursts step the two low address bits linearly or by XOR. Bursts are started by an ordinary command and continued with the advance input. Writes that have been accepted but not yet committed to the array are forwarded lane by lane to any read that needs them. Three chip selects, an asynchronous output enable and an asynchronous sleep input control selection and the data drivers.

Top module: `nbt_sram`

## Requirements
- R1: A new command is accepted at an edge only when `cs_a`, `cs_b` and `cs_c` are all 1, `adv` is 0 and `sleep` is 0. Any other combination with `adv` at 0 is a deselect: it returns no read data and writes nothing.
- R2: With `flow_mode` at 0, a read accepted at edge T drives its data on `rdata`, with `drv_en` at 1, from just after edge T+1 until edge T+2.
- R3: With `flow_mode` at 1, a read accepted at edge T drives its data from just after edge T until edge T+1.
- R4: The write data for a command accepted at edge T is sampled from `wdata` at edge T+2 in pipelined mode and at edge T+1 in flow-through mode.
- R5: Lane i is `wdata[9i+8:9i]`. It is written only if `lane_we[i]` was 1 at the edge where the write command (or burst beat) was accepted. The other lanes keep their contents.
- R6: A read returns the newest data for every lane, including writes whose data arrives at the same edge as the read's array access. Reads and writes may alternate in consecutive cycles with no idle cycle.
- R7: While a burst is in progress, a cycle with `adv` at 1 produces the next beat at beat count k = 1, 2, 3, 0, … (it wraps after four beats). The beat repeats the starting command's read/write type and upper address bits and ignores `we` and the chip selects. In linear order (`ilv_order` = 0) the two low address bits are (base + k) mod 4.
- R8: In interleaved order (`ilv_order` = 1), the two low address bits of beat k are base XOR k.
- R9: A cycle with `adv` at 1 and no burst in progress is a deselect. Any deselect ends the burst in progress.
- R10: `oe` at 0 or `sleep` at 1 turns the drivers off at once, without waiting for a clock edge: `drv_en` is 0 and `rdata` is all zeros.
- R11: A cycle whose edge sees `sleep` at 1 is a deselect and ends any burst.
- R12: While `rst_n` is low, `drv_en` and `rdata` are 0 and all pending commands and bursts are cleared. After `rst_n` rises, the first edge that accepts a command is the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released after two edges |
| cs_a | input | 1 | Chip select A, active high |
| cs_b | input | 1 | Chip select B, active high |
| cs_c | input | 1 | Chip select C, active high |
| adv | input | 1 | Continue the burst in progress |
| we | input | 1 | 1 = write command, 0 = read command |
| lane_we | input | LANES | Per-lane write enables, captured with the command |
| addr | input | ADDR_W | Word address of a new command |
| wdata | input | LANES*LANE_W | Late write data |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep; drivers off and cycles deselected |
| flow_mode | input | 1 | Static: 1 = flow-through, 0 = pipelined |
| ilv_order | input | 1 | Static: 1 = interleaved burst, 0 = linear burst |
| rdata | output | LANES*LANE_W | Read data, zero while the drivers are off |
| drv_en | output | 1 | 1 while the data drivers are on |

## Verification
The assertions assume three things about the inputs: `flow_mode` and `ilv_order` change only while reset is held, write data is present at exactly the lag edge its mode defines, and reads go only to lanes that have already been written, since the array is not reset. The stimulus changes the mode pair only inside a reset pulse. It places each write's data in the row of the lag edge and writes whole words before reading any partial-lane merge. All inputs are driven on the falling edge, and `oe` and `sleep` pulses that test the asynchronous path never cover a rising edge.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;

  // Low two address bits of burst beat `beat` from the base's low bits.
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input logic       interleave);
    return interleave ? (base ^ beat) : (base + beat);
  endfunction

endpackage

// File: rtl/nbt_burst_ctrl.sv
module nbt_burst_ctrl
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              selected,   // all selects high and awake
  input  logic              awake,
  input  logic              adv,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ilv,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr
);

  localparam int BEAT_W = 2;

  logic              active_q, active_d;
  logic              write_q;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic              new_cmd, go_burst;

  always_comb begin
    new_cmd   = !adv && selected;
    go_burst  = adv && active_q && awake;
    cnt_inc   = cnt_q + BEAT_W'(1);
    active_d  = 1'b0;
    cnt_d     = cnt_q;
    cmd_valid = 1'b0;
    cmd_write = we;
    cmd_addr  = addr;
    if (new_cmd) begin
      active_d  = 1'b1;
      cnt_d     = '0;
      cmd_valid = 1'b1;
    end else if (go_burst) begin
      active_d  = 1'b1;
      cnt_d     = cnt_inc;
      cmd_valid = 1'b1;
      cmd_write = write_q;
      cmd_addr  = {base_q[ADDR_W-1:BEAT_W],
                   beat_low(base_q[BEAT_W-1:0], cnt_inc, ilv)};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      write_q  <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      if (new_cmd) begin
        write_q <= we;
        base_q  <= addr;
      end
      if (new_cmd || go_burst) cnt_q <= cnt_d;
    end
  end

  // R7: a continued beat keeps the burst's upper address and direction
  assert_burst_keep_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && adv) |-> (cmd_addr[ADDR_W-1:BEAT_W] == $past(cmd_addr[ADDR_W-1:BEAT_W]))
                           && (cmd_write == $past(cmd_write)));

  // R7: linear order steps the low bits by one, modulo four
  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && adv && !ilv) |-> cmd_addr[BEAT_W-1:0] == $past(cmd_addr[BEAT_W-1:0]) + BEAT_W'(1));

endmodule

// File: rtl/nbt_write_pipe.sv
module nbt_write_pipe #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              flow,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lanes,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [LANES-1:0]  commit_lanes,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);

  typedef struct packed {
    logic              v;
    logic              w;
    logic [ADDR_W-1:0] a;
    logic [LANES-1:0]  l;
  } stage_t;

  stage_t s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q.v <= in_valid;
      s1_q.w <= in_write;
      if (in_valid) begin
        s1_q.a <= in_addr;
        s1_q.l <= in_lanes;
      end
      s2_q.v <= s1_q.v;
      s2_q.w <= s1_q.w;
      if (s1_q.v) begin
        s2_q.a <= s1_q.a;
        s2_q.l <= s1_q.l;
      end
    end
  end

  always_comb begin
    if (flow) begin
      commit_en    = s1_q.v && s1_q.w;
      commit_addr  = s1_q.a;
      commit_lanes = s1_q.l;
      rd_en        = in_valid && !in_write;
      rd_addr      = in_addr;
    end else begin
      commit_en    = s2_q.v && s2_q.w;
      commit_addr  = s2_q.a;
      commit_lanes = s2_q.l;
      rd_en        = s1_q.v && !s1_q.w;
      rd_addr      = s1_q.a;
    end
  end

  // R4: flow-through commits the write accepted one edge earlier
  assert_flow_lag_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (flow && commit_en) |-> $past(in_valid && in_write) && (commit_addr == $past(in_addr)));

  // R4: pipelined commits the write accepted two edges earlier
  assert_pipe_lag_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!flow && commit_en) |-> $past(in_valid && in_write, 2));

endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_q,
  output logic                    rd_vld_q
);

  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] stored, merged;
  logic          hit;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_lanes[i]) mem[wr_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  assign stored = mem[rd_addr];
  assign hit    = wr_en && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_fwd
    assign merged[g*LANE_W +: LANE_W] = (hit && wr_lanes[g]) ? wdata[g*LANE_W +: LANE_W]
                                                             : stored[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      rd_vld_q <= rd_en;
      if (rd_en) rd_q <= merged;
    end
  end

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_a,
  input  logic                    cs_b,
  input  logic                    cs_c,
  input  logic                    adv,
  input  logic                    we,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic                    flow_mode,
  input  logic                    ilv_order,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    drv_en
);

  localparam int DW = LANES * LANE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              awake, selected;
  logic              cmd_valid, cmd_write;
  logic [ADDR_W-1:0] cmd_addr;
  logic              commit_en, rd_en;
  logic [ADDR_W-1:0] commit_addr, rd_addr;
  logic [LANES-1:0]  commit_lanes;
  logic [DW-1:0]     rd_q;
  logic              rd_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign awake    = !sleep;
  assign selected = cs_a && cs_b && cs_c && awake;

  nbt_burst_ctrl #(.ADDR_W(ADDR_W)) u_burst (
    .clk, .rst_ni, .selected, .awake, .adv, .we, .addr,
    .ilv(ilv_order), .cmd_valid, .cmd_write, .cmd_addr
  );

  nbt_write_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk, .rst_ni, .flow(flow_mode),
    .in_valid(cmd_valid), .in_write(cmd_write), .in_addr(cmd_addr), .in_lanes(lane_we),
    .commit_en, .commit_addr, .commit_lanes, .rd_en, .rd_addr
  );

  nbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk, .rst_ni,
    .wr_en(commit_en), .wr_addr(commit_addr), .wr_lanes(commit_lanes), .wdata,
    .rd_en, .rd_addr, .rd_q, .rd_vld_q(rd_vld)
  );

  assign drv_en = rd_vld && oe && !sleep;
  assign rdata  = drv_en ? rd_q : '0;

  // R3: flow-through read data follows its command by one edge
  assert_flow_read_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (flow_mode && rd_vld) |-> $past(cmd_valid && !cmd_write));

  // R2: pipelined read data follows its command by two edges
  assert_pipe_read_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!flow_mode && rd_vld) |-> $past(cmd_valid && !cmd_write, 2));

  // R11: an edge seen in sleep yields no flow-through read
  assert_sleep_drop_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (flow_mode && sleep) |=> !rd_vld);

endmodule

// File: tb/test_nbt_sram.sv
module test_nbt_sram;

  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  typedef struct packed {
    logic          flow;
    logic          ilv;
    logic [2:0]    cs;
    logic          adv;
    logic          we;
    logic [NL-1:0] lanes;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic          xdrv;
    logic [DW-1:0] xdat;
    logic [3:0]    req;
  } vec_t;

  localparam logic [DW-1:0] Z   = '0;
  localparam logic [DW-1:0] D0  = {9'h101, 9'h102, 9'h103, 9'h104};
  localparam logic [DW-1:0] D1  = {9'h111, 9'h112, 9'h113, 9'h114};
  localparam logic [DW-1:0] D2  = {9'h1AA, 9'h1AA, 9'h1AA, 9'h0CC};
  localparam logic [DW-1:0] M0  = {9'h101, 9'h102, 9'h103, 9'h0CC};
  localparam logic [DW-1:0] B0  = {4{9'h0B0}};
  localparam logic [DW-1:0] B1  = {4{9'h0B1}};
  localparam logic [DW-1:0] B2  = {4{9'h0B2}};
  localparam logic [DW-1:0] B3  = {4{9'h0B3}};
  localparam logic [DW-1:0] E0  = {4{9'h0E0}};
  localparam logic [DW-1:0] G0  = {4{9'h0C0}};
  localparam logic [DW-1:0] G1  = {4{9'h0C1}};
  localparam logic [DW-1:0] G2  = {4{9'h0C2}};
  localparam logic [DW-1:0] G3  = {4{9'h0C3}};
  localparam logic [DW-1:0] H   = {9'h1AA, 9'h0EE, 9'h1AA, 9'h1AA};
  localparam logic [DW-1:0] G3H = {9'h0C3, 9'h0EE, 9'h0C3, 9'h0C3};

  localparam int NV = 35;
  // Each row is consumed at one rising edge; its expectation is sampled at the next falling edge.
  localparam vec_t TBL [NV] = '{
    // pipelined, linear
    '{1'b0,1'b0,3'd7,1'b0,1'b1,4'hF,6'h10,Z, 1'b0,Z,  4'd4},  // R4 write 0x10
    '{1'b0,1'b0,3'd7,1'b0,1'b1,4'hF,6'h11,Z, 1'b0,Z,  4'd4},  // R4 write 0x11
    '{1'b0,1'b0,3'd7,1'b0,1'b0,4'h0,6'h10,D0,1'b0,Z,  4'd2},  // R2 read, data of row 0
    '{1'b0,1'b0,3'd7,1'b0,1'b0,4'h0,6'h11,D1,1'b1,D0, 4'd2},  // R2 first read appears
    '{1'b0,1'b0,3'd7,1'b0,1'b1,4'h1,6'h10,Z, 1'b1,D1, 4'd6},  // R6 read->write no idle
    '{1'b0,1'b0,3'd7,1'b0,1'b0,4'h0,6'h10,Z, 1'b0,Z,  4'd6},  // R6 write->read no idle
    '{1'b0,1'b0,3'd0,1'b0,1'b0,4'h0,6'h00,D2,1'b1,M0, 4'd5},  // R5 lane-0 merge forwarded
    '{1'b0,1'b0,3'd7,1'b0,1'b1,4'hF,6'h22,Z, 1'b0,Z,  4'd7},  // R7 write burst at 0x22
    '{1'b0,1'b0,3'd0,1'b1,1'b0,4'hF,6'h00,Z, 1'b0,Z,  4'd7},  // R7 beat 0x23
    '{1'b0,1'b0,3'd0,1'b1,1'b0,4'hF,6'h00,B0,1'b0,Z,  4'd7},  // R7 beat 0x20
    '{1'b0,1'b0,3'd0,1'b1,1'b0,4'hF,6'h00,B1,1'b0,Z,  4'd7},  // R7 beat 0x21
    '{1'b0,1'b0,3'd7,1'b0,1'b0,4'h0,6'h22,B2,1'b0,Z,  4'd7},  // R7 read burst at 0x22
    '{1'b0,1'b0,3'd0,1'b1,1'b1,4'h0,6'h00,B3,1'b1,B0, 4'd7},  // R7 we ignored in burst
    '{1'b0,1'b0,3'd0,1'b1,1'b0,4'h0,6'h00,Z, 1'b1,B1, 4'd7},
    '{1'b0,1'b0,3'd0,1'b1,1'b0,4'h0,6'h00,Z, 1'b1,B2, 4'd7},
    '{1'b0,1'b0,3'd0,1'b0,1'b0,4'h0,6'h00,Z, 1'b1,B3, 4'd7},
    '{1'b0,1'b0,3'd7,1'b1,1'b0,4'h0,6'h10,Z, 1'b0,Z,  4'd9},  // R9 adv with no burst
    '{1'b0,1'b0,3'd0,1'b0,1'b0,4'h0,6'h00,Z, 1'b0,Z,  4'd9},  // R9 nothing returned
    '{1'b0,1'b0,3'd5,1'b0,1'b0,4'h0,6'h10,Z, 1'b0,Z,  4'd1},  // R1 one select low
    '{1'b0,1'b0,3'd7,1'b0,1'b0,4'h0,6'h10,Z, 1'b0,Z,  4'd1},  // R1 no data from row 18
    '{1'b0,1'b0,3'd0,1'b0,1'b0,4'h0,6'h00,Z, 1'b1,M0, 4'd1},  // R1 full select reads
    // flow-through, interleaved
    '{1'b1,1'b1,3'd7,1'b0,1'b1,4'hF,6'h05,Z, 1'b0,Z,  4'd4},  // R4 write 0x05
    '{1'b1,1'b1,3'd7,1'b0,1'b0,4'h0,6'h05,E0,1'b1,E0, 4'd3},  // R3 R6 forwarded at once
    '{1'b1,1'b1,3'd7,1'b0,1'b1,4'hF,6'h0D,Z, 1'b0,Z,  4'd8},  // R8 write burst at 0x0D
    '{1'b1,1'b1,3'd0,1'b1,1'b0,4'hF,6'h00,G0,1'b0,Z,  4'd8},  // R8 beat 0x0C
    '{1'b1,1'b1,3'd0,1'b1,1'b0,4'hF,6'h00,G1,1'b0,Z,  4'd8},  // R8 beat 0x0F
    '{1'b1,1'b1,3'd0,1'b1,1'b0,4'hF,6'h00,G2,1'b0,Z,  4'd8},  // R8 beat 0x0E
    '{1'b1,1'b1,3'd7,1'b0,1'b0,4'h0,6'h0D,G3,1'b1,G0, 4'd8},  // R8 read burst at 0x0D
    '{1'b1,1'b1,3'd0,1'b1,1'b0,4'h0,6'h00,Z, 1'b1,G1, 4'd8},
    '{1'b1,1'b1,3'd0,1'b1,1'b0,4'h0,6'h00,Z, 1'b1,G2, 4'd8},
    '{1'b1,1'b1,3'd0,1'b1,1'b0,4'h0,6'h00,Z, 1'b1,G3, 4'd8},
    '{1'b1,1'b1,3'd0,1'b1,1'b0,4'h0,6'h00,Z, 1'b1,G0, 4'd7},  // R7 wrap to first beat
    '{1'b1,1'b1,3'd7,1'b0,1'b1,4'h4,6'h0E,Z, 1'b0,Z,  4'd5},  // R5 lane-2 write
    '{1'b1,1'b1,3'd7,1'b0,1'b0,4'h0,6'h0E,H, 1'b1,G3H,4'd5},  // R5 R6 only lane 2 changes
    '{1'b1,1'b1,3'd0,1'b0,1'b0,4'h0,6'h00,Z, 1'b0,Z,  4'd3}
  };

  logic          clk;
  logic          rst_n;
  logic          cs_a, cs_b, cs_c, adv, we, oe, sleep, flow_mode, ilv_order;
  logic [NL-1:0] lane_we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          drv_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  nbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_nbt_sram (
    .clk, .rst_n, .cs_a, .cs_b, .cs_c, .adv, .we, .lane_we, .addr, .wdata,
    .oe, .sleep, .flow_mode, .ilv_order, .rdata, .drv_en
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_out(input string tag, input logic xd, input logic [DW-1:0] xv);
    logic [DW-1:0] xr;
    xr = xd ? xv : '0;
    total++;
    if (drv_en !== xd || rdata !== xr) begin
      bad++;
      $display("FAIL %s: drv_en=%0b rdata=%h expected drv_en=%0b rdata=%h",
               tag, drv_en, rdata, xd, xr);
    end
  endtask

  task automatic drive_idle();
    {cs_a, cs_b, cs_c} = 3'b000;
    adv = 1'b0; we = 1'b0; lane_we = '0; addr = '0; wdata = '0;
  endtask

  task automatic drive_cmd(input logic [2:0] cs, input logic a, input logic w,
                           input logic [NL-1:0] l, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    {cs_a, cs_b, cs_c} = cs;
    adv = a; we = w; lane_we = l; addr = ad; wdata = d;
  endtask

  task automatic do_reset(input logic fm, input logic io);
    drive_idle();
    rst_n = 1'b0;
    flow_mode = fm; ilv_order = io;
    @(negedge clk); @(negedge clk);
    check_out("R12 outputs in reset", 1'b0, Z);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; oe = 1'b1; sleep = 1'b0; flow_mode = 1'b0; ilv_order = 1'b0;
    drive_idle();
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      if (i == 0 || TBL[i].flow != TBL[i-1].flow || TBL[i].ilv != TBL[i-1].ilv)
        do_reset(TBL[i].flow, TBL[i].ilv);
      drive_cmd(TBL[i].cs, TBL[i].adv, TBL[i].we, TBL[i].lanes, TBL[i].addr, TBL[i].wd);
      @(posedge clk); @(negedge clk);
      check_out($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].xdrv, TBL[i].xdat);
    end

    // R12: pending state cleared, two edges of release latency
    drive_idle();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check_out("R12 drivers off in reset", 1'b0, Z);
    drive_cmd(3'd7, 1'b0, 1'b0, '0, 6'h05, Z);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_out("R12 first edge after release ignored", 1'b0, Z);
    @(posedge clk); @(negedge clk);
    check_out("R12 second edge after release ignored", 1'b0, Z);
    @(posedge clk); @(negedge clk);
    check_out("R12 third edge accepts read", 1'b1, E0);

    // R10: asynchronous driver control
    oe = 1'b0; #1;
    check_out("R10 oe low drops drivers", 1'b0, Z);
    oe = 1'b1; #1;
    check_out("R10 oe high restores drivers", 1'b1, E0);
    sleep = 1'b1; #1;
    check_out("R10 sleep drops drivers", 1'b0, Z);
    sleep = 1'b0; #1;
    check_out("R10 sleep release restores", 1'b1, E0);

    // R11: edge in sleep is a deselect and ends the burst
    sleep = 1'b1;
    @(posedge clk); @(negedge clk);
    sleep = 1'b0; #1;
    check_out("R11 read during sleep dropped", 1'b0, Z);
    drive_cmd(3'd7, 1'b0, 1'b0, '0, 6'h05, Z);
    @(posedge clk); @(negedge clk);
    check_out("R11 burst start after sleep", 1'b1, E0);
    drive_cmd(3'd0, 1'b1, 1'b0, '0, '0, Z);
    sleep = 1'b1;
    @(posedge clk); @(negedge clk);
    sleep = 1'b0; #1;
    check_out("R11 advance in sleep dropped", 1'b0, Z);
    @(posedge clk); @(negedge clk);
    check_out("R11 burst ended by sleep", 1'b0, Z);

    drive_idle();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule